// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit AES-128 ciphertext block back into plaintext, one inverse round per clock. A single round datapath and a state register that feeds back on itself do all ten inverse rounds. A one-cycle `start` pulse while the block is idle captures the ciphertext and the key input. Ten clocks later `done` pulses for one cycle, and `plaintext` then holds the result.

The key input is not the cipher key. It is the subkey of the final encryption round, which the system is expected to have worked out once and kept. The block runs the key expansion backwards from that subkey, so each earlier round key is produced in the same cycle that uses it, and no table of round keys is stored.

By default the inverse column mix is built as a small column pre-transform followed by the forward column mix. A parameter selects the direct dense-matrix form in its place, and both forms give the same result.

Top module: `aes_decrypt_rounds`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `done` is 0 and `plaintext` is all zeros.
- R2: When `start` is sampled high at a rising clock edge while idle, `ciphertext` and `last_key` (the round-10 subkey) are captured. The finished `plaintext` equals the AES-128 decryption of that block. Bytes are big-endian: byte 0 is bits [127:120], and the state is filled column by column.
- R3: `done` goes high for exactly one cycle, after the 10th rising edge that follows the edge that accepted `start`.
- R4: A `start` that arrives while a block is being decrypted is ignored. The running block's result and `done` timing are unchanged, and no extra `done` appears later.
- R5: While idle and with `start` low, `plaintext` keeps its value whatever `ciphertext` and `last_key` do.
- R6: A `start` given in the same cycle that `done` is high is accepted, so blocks can follow each other every 10 cycles.
- R7: With `DENSE_INV_MIX` set to 1, the block gives the same plaintext and timing as the default pre-transform form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin decrypting a block (accepted only while idle) |
| ciphertext | input | 128 | Block to decrypt |
| last_key | input | 128 | Round-10 subkey of the key schedule |
| plaintext | output | 128 | Decrypted block, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle pulse when the plaintext is ready |

## Verification
The bench decrypts two standard vectors, each starting from its round-10 key. A fault in the reversed key steps, for example a round constant stepped in the wrong order or a missing word XOR, corrupts every result byte. A column mix wrongly applied in the last round does the same.

The bench starts a second block halfway through a run. A core that accepted it would restart and either report the wrong plaintext or raise `done` late or twice.

It also starts a block in the same cycle as `done` to catch an off-by-one stall. It changes the inputs while the block is idle to catch a result register that follows the inputs.

Finally, it runs the dense-matrix variant alongside the default and checks that both give the same plaintext.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned BLK_BITS  = 128;
   localparam int unsigned BYTE_CNT  = BLK_BITS / 8;
   localparam int unsigned WORD_CNT  = BLK_BITS / 32;

   function automatic logic [7:0] gf_x2(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc, sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_x2(sh);
      end
      return acc;
   endfunction

   // multiplicative inverse as x^254 (zero maps to zero)
   function automatic logic [7:0] gf_recip(input logic [7:0] x);
      logic [7:0] res, base;
      logic [7:0] expo;
      res  = 8'h01;
      base = x;
      expo = 8'd254;
      for (int i = 0; i < 8; i++) begin
         if (expo[i]) res = gf_mul(res, base);
         base = gf_mul(base, base);
      end
      return res;
   endfunction

   function automatic logic [7:0] rol8(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] sub_fwd(input logic [7:0] x);
      logic [7:0] t;
      t = gf_recip(x);
      return t ^ rol8(t, 1) ^ rol8(t, 2) ^ rol8(t, 3) ^ rol8(t, 4) ^ 8'h63;
   endfunction

   function automatic logic [7:0] sub_inv(input logic [7:0] y);
      logic [7:0] t;
      t = rol8(y, 1) ^ rol8(y, 3) ^ rol8(y, 6) ^ 8'h05;
      return gf_recip(t);
   endfunction

   // round constant used by encryption round n (n >= 1)
   function automatic logic [7:0] rcon_at(input int n);
      logic [7:0] r;
      r = 8'h01;
      for (int i = 1; i < n; i++) r = gf_x2(r);
      return r;
   endfunction

   // inverse of gf_x2: previous round constant
   function automatic logic [7:0] rcon_back(input logic [7:0] r);
      return r[0] ? ((r ^ 8'h1b) >> 1) | 8'h80 : (r >> 1);
   endfunction

   function automatic logic [7:0] byte_of(input logic [BLK_BITS-1:0] v, input int b);
      return v[BLK_BITS-1-8*b -: 8];
   endfunction
endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane #(
   parameter bit INVERSE = 1'b0
) (
   input  logic [7:0] din,
   output logic [7:0] dout
);
   timeunit 1ns;
   timeprecision 1ps;
   import aes_dec_pkg::*;

   generate
      if (INVERSE) begin : g_inv
         always_comb dout = sub_inv(din);
      end else begin : g_fwd
         always_comb dout = sub_fwd(din);
      end
   endgenerate
endmodule

// File: rtl/aes_inv_key_step.sv
module aes_inv_key_step #(
   parameter int unsigned KEY_BITS = 128
) (
   input  logic [KEY_BITS-1:0] key_next,
   input  logic [7:0]          rcon,
   output logic [KEY_BITS-1:0] key_prev
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned NW = KEY_BITS / 32;

   if (KEY_BITS != 128) begin : g_bad_width
      $error("aes_inv_key_step supports a 128-bit key only");
   end

   logic [31:0] wn [NW];
   logic [31:0] wp [NW];
   logic [31:0] rot_w, sub_w;

   for (genvar j = 0; j < NW; j++) begin : g_split
      assign wn[j] = key_next[KEY_BITS-1-32*j -: 32];
      assign key_prev[KEY_BITS-1-32*j -: 32] = wp[j];
   end

   // trailing words: w[i-4] = w[i] ^ w[i-1]
   for (genvar j = 1; j < NW; j++) begin : g_tail
      assign wp[j] = wn[j] ^ wn[j-1];
   end

   assign rot_w = {wp[NW-1][23:0], wp[NW-1][31:24]};

   for (genvar b = 0; b < 4; b++) begin : g_sub
      aes_sbox_lane #(.INVERSE(1'b0)) u_sb (
         .din  (rot_w[31-8*b -: 8]),
         .dout (sub_w[31-8*b -: 8])
      );
   end

   assign wp[0] = wn[0] ^ sub_w ^ {rcon, 24'h000000};
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round #(
   parameter int unsigned BLK_BITS      = 128,
   parameter bit          DENSE_INV_MIX = 1'b0
) (
   input  logic [BLK_BITS-1:0] state_in,
   input  logic [BLK_BITS-1:0] round_key,
   input  logic                last_round,
   output logic [BLK_BITS-1:0] state_out
);
   timeunit 1ns;
   timeprecision 1ps;
   import aes_dec_pkg::*;

   localparam int unsigned NB   = BLK_BITS / 8;
   localparam int unsigned NCOL = NB / 4;

   if (BLK_BITS != 128) begin : g_bad_width
      $error("aes_inv_round supports a 128-bit state only");
   end

   logic [7:0] s_in [NB];
   logic [7:0] shr  [NB];
   logic [7:0] sbo  [NB];
   logic [7:0] akb  [NB];
   logic [7:0] mxb  [NB];

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam int R   = b % 4;
      localparam int C   = b / 4;
      localparam int SRC = R + 4 * ((C - R + NCOL) % NCOL);
      assign s_in[b] = state_in[BLK_BITS-1-8*b -: 8];
      assign shr[b]  = s_in[SRC];
      aes_sbox_lane #(.INVERSE(1'b1)) u_isb (
         .din  (shr[b]),
         .dout (sbo[b])
      );
      assign akb[b] = sbo[b] ^ round_key[BLK_BITS-1-8*b -: 8];
      assign state_out[BLK_BITS-1-8*b -: 8] = last_round ? akb[b] : mxb[b];
   end

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic [7:0] a0, a1, a2, a3;
      assign a0 = akb[4*c];
      assign a1 = akb[4*c+1];
      assign a2 = akb[4*c+2];
      assign a3 = akb[4*c+3];
      if (DENSE_INV_MIX) begin : g_dense
         always_comb begin
            mxb[4*c]   = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
            mxb[4*c+1] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
            mxb[4*c+2] = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
            mxb[4*c+3] = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
         end
      end else begin : g_pre
         logic [7:0] u, v, p0, p1, p2, p3;
         always_comb begin
            u  = gf_x2(gf_x2(a0 ^ a2));
            v  = gf_x2(gf_x2(a1 ^ a3));
            p0 = a0 ^ u;
            p2 = a2 ^ u;
            p1 = a1 ^ v;
            p3 = a3 ^ v;
            mxb[4*c]   = gf_x2(p0) ^ gf_x2(p1) ^ p1 ^ p2 ^ p3;
            mxb[4*c+1] = p0 ^ gf_x2(p1) ^ gf_x2(p2) ^ p2 ^ p3;
            mxb[4*c+2] = p0 ^ p1 ^ gf_x2(p2) ^ gf_x2(p3) ^ p3;
            mxb[4*c+3] = gf_x2(p0) ^ p0 ^ p1 ^ p2 ^ gf_x2(p3);
         end
      end
   end
endmodule

// File: rtl/aes_decrypt_rounds.sv
module aes_decrypt_rounds #(
   parameter int unsigned BLK_BITS      = 128,
   parameter int unsigned NR            = 10,
   parameter bit          DENSE_INV_MIX = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BLK_BITS-1:0] ciphertext,
   input  logic [BLK_BITS-1:0] last_key,
   output logic [BLK_BITS-1:0] plaintext,
   output logic                done
);
   timeunit 1ns;
   timeprecision 1ps;
   import aes_dec_pkg::*;

   localparam int unsigned CNT_W     = $clog2(NR);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NR - 1);
   localparam logic [7:0] RCON_FIRST = rcon_at(NR);

   if (BLK_BITS != 128) begin : g_bad_width
      $error("aes_decrypt_rounds: block width must be 128");
   end
   if (NR != 10) begin : g_bad_rounds
      $error("aes_decrypt_rounds: AES-128 needs exactly 10 rounds");
   end

   logic [BLK_BITS-1:0] state_q, key_q, key_prev, round_out;
   logic [7:0]          rcon_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                busy_q, done_q;
   logic                last_rnd;

   assign last_rnd = (cnt_q == LAST);

   aes_inv_key_step #(.KEY_BITS(BLK_BITS)) u_kstep (
      .key_next (key_q),
      .rcon     (rcon_q),
      .key_prev (key_prev)
   );

   aes_inv_round #(.BLK_BITS(BLK_BITS), .DENSE_INV_MIX(DENSE_INV_MIX)) u_round (
      .state_in   (state_q),
      .round_key  (key_prev),
      .last_round (last_rnd),
      .state_out  (round_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         key_q   <= '0;
         rcon_q  <= 8'h00;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (busy_q) begin
         state_q <= round_out;
         key_q   <= key_prev;
         rcon_q  <= rcon_back(rcon_q);
         cnt_q   <= cnt_q + 1'b1;
         busy_q  <= !last_rnd;
         done_q  <= last_rnd;
      end else if (start) begin
         state_q <= ciphertext ^ last_key;
         key_q   <= last_key;
         rcon_q  <= RCON_FIRST;
         cnt_q   <= '0;
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q  <= 1'b0;
      end
   end

   assign plaintext = state_q;
   assign done      = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R3
   AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(busy_q)); // R3
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_rnd) |=> (busy_q && !done_q)); // R4
   AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> $stable(plaintext)); // R5
   AST_RCON_ENDS_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last_rnd) |-> (rcon_q == 8'h01)); // R2
endmodule

// File: tb/test_aes_decrypt_rounds.sv
module test_aes_decrypt_rounds;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [127:0] CT_A = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
   localparam logic [127:0] K_A  = 128'h13111d7fe3944a17f307a78b4d2b30c5;
   localparam logic [127:0] PT_A = 128'h00112233445566778899aabbccddeeff;
   localparam logic [127:0] CT_B = 128'h3925841d02dc09fbdc118597196a0b32;
   localparam logic [127:0] K_B  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
   localparam logic [127:0] PT_B = 128'h3243f6a8885a308d313198a2e0370734;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] ct = '0, key = '0;
   logic [127:0] pt, pt_d;
   logic         done, done_d;
   int           n_run = 0, n_fail = 0;
   bit           ended = 1'b0;

   always #4 clk = ~clk;

   aes_decrypt_rounds i_aes_decrypt_rounds (
      .clk(clk), .rst_n(rst_n), .start(start), .ciphertext(ct),
      .last_key(key), .plaintext(pt), .done(done)
   );

   aes_decrypt_rounds #(.DENSE_INV_MIX(1'b1)) i_aes_decrypt_rounds_dense (
      .clk(clk), .rst_n(rst_n), .start(start), .ciphertext(ct),
      .last_key(key), .plaintext(pt_d), .done(done_d)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive start at a falling edge; returns after the accepting edge
   task automatic kick(input logic [127:0] c, input logic [127:0] k);
      ct = c; key = k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // watch 10 edges, check done only at the 10th, then the result
   task automatic run_block(input string tag, input logic [127:0] c,
                            input logic [127:0] k, input logic [127:0] exp);
      int early = 0;
      kick(c, k);
      for (int i = 1; i < 10; i++) begin
         @(negedge clk);
         if (done || done_d) early++;
      end
      @(negedge clk);
      check({tag, " R3 done early"}, 128'(early), 128'd0);
      check({tag, " R3 done at 10"}, 128'(done), 128'd1);
      check({tag, " R2 plaintext"}, pt, exp);
      check({tag, " R7 dense plaintext"}, pt_d, exp);
      check({tag, " R7 dense done"}, 128'(done_d), 128'd1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 done in reset", 128'(done), 128'd0);
      check("R1 plaintext in reset", pt, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", 128'(done), 128'd0);
      check("R1 plaintext after reset", pt, 128'd0);
   endtask

   task automatic t_vectors;
      run_block("vecA", CT_A, K_A, PT_A);
      @(negedge clk);
      check("R3 done drops", 128'(done), 128'd0);
      run_block("vecB", CT_B, K_B, PT_B);
      @(negedge clk);
   endtask

   task automatic t_busy_start;
      int dones = 0;
      kick(CT_A, K_A);
      repeat (3) @(negedge clk);
      ct = CT_B; key = K_B; start = 1'b1;   // mid-run, must be ignored
      @(negedge clk);
      start = 1'b0;
      for (int i = 5; i < 10; i++) begin
         @(negedge clk);
         if (done) dones++;
      end
      @(negedge clk);
      check("R4 done on schedule", 128'(done), 128'd1);
      check("R4 result kept", pt, PT_A);
      check("R4 no early done", 128'(dones), 128'd0);
      dones = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (done) dones++;
      end
      check("R4 no extra done", 128'(dones), 128'd0);
   endtask

   task automatic t_hold;
      logic [127:0] kept;
      kept = pt;
      for (int i = 0; i < 6; i++) begin
         ct = {4{32'(i) * 32'h9e3779b9}};
         key = ~ct;
         @(negedge clk);
      end
      check("R5 plaintext held", pt, kept);
      check("R5 no done", 128'(done), 128'd0);
   endtask

   task automatic t_back_to_back;
      run_block("b2b first", CT_B, K_B, PT_B);
      // done is high now: start again in this very cycle
      run_block("R6 second", CT_A, K_A, PT_A);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      if (!ended) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_vectors();
      t_busy_start();
      t_hold();
      t_back_to_back();
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule